// File: doc/BRIEF.md
# Predicated Vector Reduction Unit

The unit folds a short vector of fixed-width elements into one scalar. A predicate mask selects the elements that take part. The fold uses one associative two-operand operation: wrapping add, multiply keeping the low half, or bitwise OR. The scalar goes into the lowest-numbered element slot whose predicate bit is set. Every slot whose predicate bit is clear is returned with the value it had on input.

The unit also produces one condition flag. Each active element has a condition bit, which is set when the running partial result after that element is folded in is nonzero. The flag reports whether any of these bits is set or whether all of them are set. A mode select bit picks between the two, and the flag is produced only when condition recording is requested.

Operation is sequential. A start pulse captures all operands. The accumulator then visits one lane per clock, and a one-cycle done strobe presents the updated vector, the flag and an illegal-operation indication. These outputs hold their values until the next done strobe.

Top module: `rvr_unit`

## Requirements
- R1: For a legal operation in reduce mode, the scalar equals a left-to-right fold of the active elements in ascending lane order. Operation code 0 is add modulo 2^16, code 1 is multiply keeping the low 16 bits, and code 2 is bitwise OR. A single active element is returned unchanged.
- R2: The scalar is written into the lowest-indexed lane whose predicate bit is 1, and not into lane 0 unless lane 0 is active. Lane i occupies vector bits [16*i+15:16*i].
- R3: A lane whose predicate bit is 0 appears on the output with exactly its input value.
- R4: In reduce mode, any operation code other than 0, 1 or 2 is illegal. This includes code 3 (subtract) and code 4 (divide). An illegal code gives illegal_o = 1 with done, the output vector equal to the input vector, and flag_o = 0.
- R5: Reduce mode is selected when mode bits [1:0] are 00 and mode bit 2 is 1. Any other mode passes the vector through unchanged, with flag_o = 0 and illegal_o = 0, whatever the operation code.
- R6: With rc_en_i = 1, flag_o is the OR of the active lanes' condition bits when mode bit 4 is 0, and the AND of those bits when mode bit 4 is 1. A lane's condition bit is 1 when the running partial result after folding that lane is nonzero.
- R7: With rc_en_i = 0, flag_o is 0.
- R8: With an all-zero predicate in reduce mode, no lane is written and done still pulses. With rc_en_i = 1, flag_o equals mode bit 4.
- R9: done_o is high for exactly one cycle. It rises on the 8th rising edge after the edge that samples start_i, and the vector, flag and illegal outputs hold until the next done.
- R10: A start pulse that arrives while an operation is in progress is ignored, and the result of the running operation is unaffected.
- R11: Mode bit 3 (the source-zeroing bit) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operand capture pulse |
| vec_i | input | 128 | Packed element vector, lane i at bits [16*i+15:16*i] |
| pred_i | input | 8 | Predicate mask, bit i enables lane i |
| op_i | input | 3 | Operation code: 0 add, 1 multiply, 2 OR, others illegal |
| mode_i | input | 5 | [1:0] kind, [2] reduce enable, [3] source zeroing, [4] all-mode flag select |
| rc_en_i | input | 1 | Condition recording enable |
| vec_o | output | 128 | Updated vector |
| done_o | output | 1 | One-cycle result strobe |
| flag_o | output | 1 | Aggregated condition flag |
| illegal_o | output | 1 | Unsupported operation indication |

## Verification
Every result of the unit becomes due on a single edge: the eighth rising edge after the edge that samples start. On that edge done, the vector, the flag and the illegal indication all change together, and they stay constant afterwards. The bench drives start on a falling edge and then steps through eight full cycles. It compares done against its own cycle count on every falling edge and checks the outputs only in the window where done is expected high. Lanes that the requirements leave undefined (active lanes other than the result slot) are not compared.

// File: rtl/rvr_pkg.sv
package rvr_pkg;

  localparam int unsigned OPW = 3;
  localparam int unsigned MDW = 5;

  // operation codes
  localparam logic [OPW-1:0] OP_ADD = 3'd0;
  localparam logic [OPW-1:0] OP_MUL = 3'd1;
  localparam logic [OPW-1:0] OP_OR  = 3'd2;

  // mode field bit positions
  localparam int unsigned MD_KIND_LO = 0;
  localparam int unsigned MD_RED_EN  = 2;
  localparam int unsigned MD_SZ      = 3;
  localparam int unsigned MD_ALL     = 4;

  function automatic logic rvr_op_legal(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_MUL) || (op == OP_OR);
  endfunction

  function automatic logic rvr_is_reduce(input logic [MDW-1:0] md);
    return (md[MD_KIND_LO +: 2] == 2'b00) && md[MD_RED_EN];
  endfunction

endpackage

// File: rtl/rvr_first_active.sv
module rvr_first_active #(
  parameter int unsigned NL = 8,
  localparam int unsigned IW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [NL-1:0] mask_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);

  // priority pick: scanning downward leaves the lowest set bit
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rvr_flag_agg.sv
module rvr_flag_agg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  input  logic test_i,
  output logic any_nx_o,
  output logic all_nx_o
);

  logic any_q, all_q, seen_q;

  assign any_nx_o = any_q | (step_i & test_i);
  assign all_nx_o = all_q & (~step_i | test_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q  <= 1'b0;
      all_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (clear_i) begin
      any_q  <= 1'b0;
      all_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (step_i) begin
      any_q  <= any_nx_o;
      all_q  <= all_nx_o;
      seen_q <= 1'b1;
    end
  end

  // R6: when every visited lane passed, at least one did
  p_all_has_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && all_q) |-> any_q);

  // R8: nothing visited means the any-summary stays clear
  p_empty_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !any_q);

endmodule

// File: rtl/rvr_unit.sv
module rvr_unit
  import rvr_pkg::*;
#(
  parameter int unsigned NL = 8,
  parameter int unsigned EW = 16,
  localparam int unsigned IW = (NL > 1) ? $clog2(NL) : 1,
  localparam int unsigned VW = NL * EW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VW-1:0]  vec_i,
  input  logic [NL-1:0]  pred_i,
  input  logic [OPW-1:0] op_i,
  input  logic [MDW-1:0] mode_i,
  input  logic           rc_en_i,
  output logic [VW-1:0]  vec_o,
  output logic           done_o,
  output logic           flag_o,
  output logic           illegal_o
);

  function automatic logic [EW-1:0] rvr_combine(input logic [OPW-1:0] op,
                                                input logic [EW-1:0] a,
                                                input logic [EW-1:0] b);
    logic [EW-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_MUL:  r = a * b;
      default: r = a | b;
    endcase
    return r;
  endfunction

  // captured operands
  logic           busy_q;
  logic [IW-1:0]  lane_q;
  logic [VW-1:0]  vec_q;
  logic [NL-1:0]  pred_q;
  logic [OPW-1:0] op_q;
  logic           red_q;
  logic           all_sel_q;
  logic           rc_q;
  logic [EW-1:0]  acc_q;
  logic           have_q;

  logic unused_sz;
  assign unused_sz = mode_i[MD_SZ];

  // named internal events
  logic          take_w;
  logic          legal_w;
  logic          last_w;
  logic          step_w;
  logic          test_w;
  logic [EW-1:0] lane_elem_w;
  logic [EW-1:0] comb_w;
  logic [EW-1:0] acc_fin_w;
  logic [IW-1:0] first_idx_w;
  logic          first_found_w;
  logic          any_nx_w, all_nx_w;
  logic          flag_d_w;
  logic [VW-1:0] result_vec_w;

  logic [EW-1:0] lanes_w [NL];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lanes_w[g] = vec_q[g*EW +: EW];
  end

  assign take_w      = start_i && !busy_q;
  assign legal_w     = rvr_op_legal(op_q);
  assign last_w      = busy_q && (lane_q == IW'(NL - 1));
  assign lane_elem_w = lanes_w[lane_q];
  assign step_w      = busy_q && pred_q[lane_q] && red_q && legal_w;
  assign comb_w      = have_q ? rvr_combine(op_q, acc_q, lane_elem_w) : lane_elem_w;
  assign test_w      = (comb_w != '0);
  assign acc_fin_w   = step_w ? comb_w : acc_q;

  rvr_first_active #(.NL(NL)) u_first (
    .mask_i  (pred_q),
    .idx_o   (first_idx_w),
    .found_o (first_found_w)
  );

  rvr_flag_agg u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (take_w),
    .step_i   (step_w),
    .test_i   (test_w),
    .any_nx_o (any_nx_w),
    .all_nx_o (all_nx_w)
  );

  assign flag_d_w = (rc_q && red_q && legal_w) ? (all_sel_q ? all_nx_w : any_nx_w) : 1'b0;

  always_comb begin
    result_vec_w = vec_q;
    if (red_q && legal_w && first_found_w)
      result_vec_w[first_idx_w*EW +: EW] = acc_fin_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      lane_q    <= '0;
      vec_q     <= '0;
      pred_q    <= '0;
      op_q      <= '0;
      red_q     <= 1'b0;
      all_sel_q <= 1'b0;
      rc_q      <= 1'b0;
      acc_q     <= '0;
      have_q    <= 1'b0;
      vec_o     <= '0;
      done_o    <= 1'b0;
      flag_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_w) begin
        busy_q    <= 1'b1;
        lane_q    <= '0;
        vec_q     <= vec_i;
        pred_q    <= pred_i;
        op_q      <= op_i;
        red_q     <= rvr_is_reduce(mode_i);
        all_sel_q <= mode_i[MD_ALL];
        rc_q      <= rc_en_i;
        have_q    <= 1'b0;
      end else if (busy_q) begin
        if (step_w) begin
          acc_q  <= comb_w;
          have_q <= 1'b1;
        end
        if (last_w) begin
          busy_q    <= 1'b0;
          done_o    <= 1'b1;
          vec_o     <= result_vec_w;
          flag_o    <= flag_d_w;
          illegal_o <= red_q && !legal_w;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: the strobe comes only after the lane walk has ended
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_q);

  // R4: rejected operation leaves the vector and flag untouched
  p_illegal_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> (vec_o == vec_q && !flag_o));

  // R5: outside reduce mode the vector passes through
  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !red_q) |-> (vec_o == vec_q && !flag_o && !illegal_o));

  // R7: no condition recording, no flag
  p_rc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rc_q) |-> !flag_o);

  // R8: empty predicate writes nothing
  p_empty_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pred_q == '0) |-> vec_o == vec_q);

  for (genvar g = 0; g < NL; g++) begin : g_chk
    // R3: masked-out lanes keep their input value
    p_inactive_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !pred_q[g]) |-> vec_o[g*EW +: EW] == vec_q[g*EW +: EW]);
  end

endmodule

// File: tb/rvr_unit_tb.sv
module rvr_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] vec_i = '0;
  logic [7:0]   pred_i = '0;
  logic [2:0]   op_i = '0;
  logic [4:0]   mode_i = '0;
  logic         rc_en_i = 1'b0;
  logic [127:0] vec_o;
  logic         done_o, flag_o, illegal_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rvr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i),
    .pred_i(pred_i), .op_i(op_i), .mode_i(mode_i), .rc_en_i(rc_en_i),
    .vec_o(vec_o), .done_o(done_o), .flag_o(flag_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model plus cycle-by-cycle comparison
  task automatic run(input logic [127:0] v, input logic [7:0] p, input logic [2:0] op,
                     input logic [4:0] md, input logic rc, input bit poke, input string tag);
    bit red, legal, have, anyb, allb;
    int unsigned acc, val;
    int first;
    logic [127:0] ev;
    red   = (md[1:0] == 2'b00) && md[2];
    legal = (op < 3);
    have = 0; anyb = 0; allb = 1; acc = 0; first = -1; ev = v;
    if (red && legal) begin
      for (int i = 0; i < 8; i++) begin
        if (p[i]) begin
          val = int'(v[16*i +: 16]);
          if (!have) acc = val;
          else if (op == 0) acc = (acc + val) % 65536;
          else if (op == 1) acc = (acc * val) % 65536;
          else acc = acc | val;
          have = 1;
          if (first < 0) first = i;
          anyb = anyb | (acc != 0);
          allb = allb & (acc != 0);
        end
      end
      if (first >= 0) ev[16*first +: 16] = acc[15:0];
    end

    @(negedge clk);
    start_i = 1'b1; vec_i = v; pred_i = p; op_i = op; mode_i = md; rc_en_i = rc;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (poke && k == 3) begin
        start_i = 1'b1; vec_i = ~v; pred_i = ~p; op_i = 3'd0; mode_i = 5'b00100;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == (k == 8), {tag, " R9 done timing"}, 128'(done_o), 128'(k == 8));
    end
    for (int i = 0; i < 8; i++) begin
      if (!(red && legal) || !p[i] || i == first)
        chk(vec_o[16*i +: 16] == ev[16*i +: 16], $sformatf("%s lane%0d", tag, i),
            128'(vec_o[16*i +: 16]), 128'(ev[16*i +: 16]));
    end
    chk(flag_o == ((red && legal && rc) ? (md[4] ? allb : anyb) : 1'b0),
        {tag, " flag"}, 128'(flag_o), 128'((red && legal && rc) ? (md[4] ? allb : anyb) : 1'b0));
    chk(illegal_o == (red && !legal), {tag, " illegal"}, 128'(illegal_o), 128'(red && !legal));
    @(negedge clk);
    chk(!done_o, {tag, " R9 single pulse"}, 128'(done_o), 128'(0));
    chk(vec_o == ev || (red && legal && p != 0), {tag, " R9 hold"}, vec_o, ev);
  endtask

  localparam logic [127:0] VA = 128'h0009_0000_0007_0005_1234_0003_8000_0011;
  localparam logic [127:0] VZ = 128'h0001_0000_0100_0100_0000_FFFB_0005_0000;

  initial begin
    repeat (3) @(negedge clk);
    chk(vec_o == '0 && !done_o && !flag_o && !illegal_o, "reset", {vec_o[124:0], done_o, flag_o, illegal_o}, '0);
    rst_n = 1'b1;
    run(VA, 8'b1011_0100, 3'd0, 5'b00100, 1'b1, 0, "R1 R2 R3 R6 add any");
    run(VA, 8'hFF, 3'd1, 5'b10100, 1'b1, 0, "R1 R2 R6 mul all");
    run(VA, 8'b1000_0000, 3'd2, 5'b00100, 1'b1, 0, "R1 R2 single or");
    run(VA, 8'b0110_1010, 3'd2, 5'b10100, 1'b1, 0, "R1 R3 or all");
    run(128'hFFFF_0003_0000_0000_0000_0000_0000_0000, 8'b1100_0000, 3'd0, 5'b00100, 1'b1, 0, "R1 add wrap");
    run(VZ, 8'b0011_0000, 3'd1, 5'b10100, 1'b1, 0, "R1 R6 mul low half");
    run(VZ, 8'b0000_0110, 3'd0, 5'b10100, 1'b1, 0, "R6 cancel all");
    run(VZ, 8'b0000_0110, 3'd0, 5'b00100, 1'b1, 0, "R6 cancel any");
    run(VA, 8'b0101_0101, 3'd3, 5'b00100, 1'b1, 0, "R4 sub rejected");
    run(VA, 8'b0101_0101, 3'd4, 5'b10100, 1'b1, 0, "R4 div rejected");
    run(VA, 8'hFF, 3'd7, 5'b00100, 1'b1, 0, "R4 code7");
    run(VA, 8'hFF, 3'd0, 5'b00101, 1'b1, 0, "R5 kind01");
    run(VA, 8'hFF, 3'd4, 5'b10000, 1'b1, 0, "R5 no enable");
    run(VA, 8'b1011_0100, 3'd0, 5'b10100, 1'b0, 0, "R7 rc off");
    run(VA, 8'h00, 3'd0, 5'b00100, 1'b1, 0, "R8 empty any");
    run(VA, 8'h00, 3'd1, 5'b10100, 1'b1, 0, "R8 empty all");
    run(VA, 8'b1011_0100, 3'd0, 5'b01100, 1'b1, 0, "R11 sz set");
    run(VA, 8'b1011_0100, 3'd1, 5'b11100, 1'b1, 0, "R11 sz set all");
    run(VA, 8'b0011_0110, 3'd0, 5'b00100, 1'b1, 1, "R10 start while busy");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule